// File: doc/BRIEF.md
# Register-Indirect Add Execution Unit

This unit executes one two-operand add per decoded operation and holds its own small file of 16-bit registers, each paired with a segment register. It supports three operand forms: both operands in registers, a register plus a memory word with the sum kept in the register, and a memory word plus a register with the sum stored back to memory. In the two memory forms one register serves as the pointer. The data-memory address is that pointer's segment value placed above the pointer's 16-bit contents.

A decoded operation is presented on the `op_*` inputs together with `op_start`. It is taken only while `busy` is low. The unit talks to a synchronous data memory that returns read data on the clock edge after the read strobe. When asked, it advances the pointer by the operand size once the memory access is complete. It then reports completion with a one-cycle `done` and leaves carry and zero flags for the result. A preload port writes a register and its segment while the unit is idle. A combinational read port shows any register and its segment.

Top module: `rind_add_unit`

## Requirements
- R1: With `op_mode` 0 (code 3 behaves the same), register `op_dst` becomes `op_dst + op_src` modulo 2^16 for a word op, and register `op_src` is unchanged; no memory strobe is raised.
- R2: With `op_mode` 1, register `op_dst` becomes its old value plus the memory cell addressed through pointer register `op_src`.
- R3: With `op_mode` 2, the memory cell addressed through pointer register `op_dst` is read, and then that same address is written with the cell value plus register `op_src`; read and write never occur in the same cycle, and no register other than the pointer changes.
- R4: The memory address is 24 bits: bits 23:16 hold the pointer's 8-bit segment and bits 15:0 hold the pointer register.
- R5: With `op_autoinc` 1 in a memory form, the pointer register grows by 2 for a word op and by 1 for a byte op (wrapping at 16 bits). This happens one cycle after the memory access completes, and the segment is unchanged. With `op_autoinc` 0 the pointer keeps its value.
- R6: With `op_byte` 1, only bits 7:0 of both operands are added. The destination keeps its old bits 15:8, whether the destination is a register or the memory cell that was read.
- R7: `flag_c` is the carry out of bit 15 (word) or bit 7 (byte), and `flag_z` is 1 when the result at that size is zero. Both are updated at write-back and held until the next operation.
- R8: `done` is high for exactly one cycle. It is the 2nd cycle after the start edge for a register form and the 4th for a memory form. `busy` is high from the cycle after the start edge through the `done` cycle.
- R9: While `busy` is high, `op_start` and the preload port `ld_en` are ignored.
- R10: After reset all registers and segments read zero, and `busy`, `done`, `flag_c`, `flag_z`, `mem_rd` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Request to begin the presented operation |
| op_mode | input | 2 | 0/3 reg+reg, 1 reg+=mem, 2 mem+=reg |
| op_dst | input | 3 | First operand register (pointer in mode 2) |
| op_src | input | 3 | Second operand register (pointer in mode 1) |
| op_byte | input | 1 | 1 = byte operation, 0 = word operation |
| op_autoinc | input | 1 | Advance the pointer after the access |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_c | output | 1 | Carry of the last result |
| flag_z | output | 1 | Zero of the last result |
| mem_addr | output | 24 | Data-memory address |
| mem_rd | output | 1 | Read strobe; data expected next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, registered by the memory |
| ld_en | input | 1 | Preload a register while idle |
| ld_idx | input | 3 | Preload register index |
| ld_val | input | 16 | Preload register value |
| ld_seg | input | 8 | Preload segment value |
| rd_idx | input | 3 | Observation register index |
| rd_val | output | 16 | Observed register value |
| rd_seg | output | 8 | Observed segment value |

## Verification
The assertions assume that the memory returns read data one cycle after `mem_rd` and holds it stable through the following cycle. They also assume that the operation fields never change the unit's state while it is busy. The bench's memory model is a registered array with exactly that one-cycle read timing. Preloads are issued only between operations. Start is driven during a busy period only in the scenario written to show that it is ignored.

// File: rtl/rind_pkg.sv
package rind_pkg;
  typedef enum logic [1:0] {
    MODE_RR  = 2'd0,
    MODE_RM  = 2'd1,
    MODE_MR  = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WB   = 3'd2,
    ST_INC  = 3'd3,
    ST_FIN  = 3'd4
  } state_e;
endpackage

// File: rtl/rind_ctrl.sv
module rind_ctrl
  import rind_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] dst_i,
  input  logic [IW-1:0] src_i,
  input  logic          byte_i,
  input  logic          ai_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rd_phase_o,
  output logic          wb_phase_o,
  output logic          inc_phase_o,
  output mode_e         mode_o,
  output logic [IW-1:0] dst_o,
  output logic [IW-1:0] src_o,
  output logic          byte_o,
  output logic          ai_o
);
  state_e        state_q, state_d;
  mode_e         mode_q, mode_d;
  logic [IW-1:0] dst_q, dst_d, src_q, src_d;
  logic          byte_q, byte_d, ai_q, ai_d;
  logic          accept, is_mem_in, is_mem_q;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign is_mem_in = (mode_i == MODE_RM) || (mode_i == MODE_MR);
  assign is_mem_q  = (mode_q == MODE_RM) || (mode_q == MODE_MR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = is_mem_in ? ST_RD : ST_WB;
      ST_RD:   state_d = ST_WB;
      ST_WB:   state_d = is_mem_q ? ST_INC : ST_FIN;
      ST_INC:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    dst_d  = dst_q;
    src_d  = src_q;
    byte_d = byte_q;
    ai_d   = ai_q;
    if (accept) begin
      mode_d = mode_e'(mode_i);
      dst_d  = dst_i;
      src_d  = src_i;
      byte_d = byte_i;
      ai_d   = ai_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RR;
      dst_q  <= '0;
      src_q  <= '0;
      byte_q <= 1'b0;
      ai_q   <= 1'b0;
    end else if (accept) begin
      mode_q <= mode_d;
      dst_q  <= dst_d;
      src_q  <= src_d;
      byte_q <= byte_d;
      ai_q   <= ai_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign rd_phase_o  = (state_q == ST_RD);
  assign wb_phase_o  = (state_q == ST_WB);
  assign inc_phase_o = (state_q == ST_INC);
  assign mode_o      = mode_q;
  assign dst_o       = dst_q;
  assign src_o       = src_q;
  assign byte_o      = byte_q;
  assign ai_o        = ai_q;

  // R8: completion pulse lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: completion only follows a busy cycle
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  // R9: latched operation fields hold while busy
  assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable({mode_q, dst_q, src_q, byte_q, ai_q}));
endmodule

// File: rtl/rind_regfile.sv
module rind_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int SW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_val,
  input  logic [SW-1:0] ld_seg,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_idx,
  input  logic [DW-1:0] inc_amt,
  input  logic [IW-1:0] a_idx,
  output logic [DW-1:0] a_val,
  input  logic [IW-1:0] b_idx,
  output logic [DW-1:0] b_val,
  input  logic [IW-1:0] p_idx,
  output logic [DW-1:0] p_val,
  output logic [SW-1:0] p_seg,
  input  logic [IW-1:0] o_idx,
  output logic [DW-1:0] o_val,
  output logic [SW-1:0] o_seg
);
  logic [DW-1:0] r_q [NREG];
  logic [DW-1:0] r_d [NREG];
  logic [SW-1:0] s_q [NREG];
  logic [SW-1:0] s_d [NREG];
  logic [NREG-1:0] r_en, s_en;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      r_d[i]  = r_q[i];
      s_d[i]  = s_q[i];
      r_en[i] = 1'b0;
      s_en[i] = 1'b0;
      if (ld_en && (ld_idx == IW'(i))) begin
        r_d[i]  = ld_val;
        s_d[i]  = ld_seg;
        r_en[i] = 1'b1;
        s_en[i] = 1'b1;
      end
      if (wr_en && (wr_idx == IW'(i))) begin
        r_d[i]  = wr_data;
        r_en[i] = 1'b1;
      end
      if (inc_en && (inc_idx == IW'(i))) begin
        r_d[i]  = r_q[i] + inc_amt;
        r_en[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        r_q[i] <= '0;
        s_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (r_en[i]) r_q[i] <= r_d[i];
        if (s_en[i]) s_q[i] <= s_d[i];
      end
    end
  end

  assign a_val = r_q[a_idx];
  assign b_val = r_q[b_idx];
  assign p_val = r_q[p_idx];
  assign p_seg = s_q[p_idx];
  assign o_val = r_q[o_idx];
  assign o_seg = s_q[o_idx];

  // R5: pointer advance never coincides with a result write
  assert_inc_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |-> !wr_en);
endmodule

// File: rtl/rind_addalu.sv
module rind_addalu #(
  parameter int DW = 16,
  localparam int LW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          byte_op,
  output logic [DW-1:0] sum,
  output logic          carry,
  output logic          zero
);
  logic [DW:0] wsum;
  logic [LW:0] lsum;

  always_comb begin
    wsum = {1'b0, a} + {1'b0, b};
    lsum = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
    if (byte_op) begin
      sum   = {a[DW-1:LW], lsum[LW-1:0]};
      carry = lsum[LW];
      zero  = (lsum[LW-1:0] == '0);
    end else begin
      sum   = wsum[DW-1:0];
      carry = wsum[DW];
      zero  = (wsum[DW-1:0] == '0);
    end
  end
endmodule

// File: rtl/rind_add_unit.sv
module rind_add_unit
  import rind_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int SW   = 8,
  localparam int IW  = $clog2(NREG),
  localparam int AW  = DW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [1:0]    op_mode,
  input  logic [IW-1:0] op_dst,
  input  logic [IW-1:0] op_src,
  input  logic          op_byte,
  input  logic          op_autoinc,
  output logic          busy,
  output logic          done,
  output logic          flag_c,
  output logic          flag_z,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_val,
  input  logic [SW-1:0] ld_seg,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_val,
  output logic [SW-1:0] rd_seg
);
  mode_e         mode_q;
  logic [IW-1:0] dst_q, src_q, ptr_idx;
  logic          byte_q, ai_q;
  logic          rd_phase, wb_phase, inc_phase;
  logic [DW-1:0] dst_val, src_val, ptr_val, opa, opb, sum, inc_amt;
  logic [SW-1:0] ptr_seg;
  logic          c_comb, z_comb, reg_wr, mem_dst;
  logic          c_q, c_d, z_q, z_d;

  rind_ctrl #(.IW(IW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(op_start), .mode_i(op_mode),
    .dst_i(op_dst), .src_i(op_src), .byte_i(op_byte), .ai_i(op_autoinc),
    .busy_o(busy), .done_o(done), .rd_phase_o(rd_phase),
    .wb_phase_o(wb_phase), .inc_phase_o(inc_phase), .mode_o(mode_q),
    .dst_o(dst_q), .src_o(src_q), .byte_o(byte_q), .ai_o(ai_q)
  );

  assign mem_dst = (mode_q == MODE_MR);
  assign ptr_idx = mem_dst ? dst_q : src_q;
  assign reg_wr  = wb_phase && !mem_dst;
  assign inc_amt = !ai_q ? '0 : (byte_q ? DW'(1) : DW'(2));

  rind_regfile #(.NREG(NREG), .DW(DW), .SW(SW)) i_rf (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en && !busy), .ld_idx(ld_idx), .ld_val(ld_val), .ld_seg(ld_seg),
    .wr_en(reg_wr), .wr_idx(dst_q), .wr_data(sum),
    .inc_en(inc_phase), .inc_idx(ptr_idx), .inc_amt(inc_amt),
    .a_idx(dst_q), .a_val(dst_val), .b_idx(src_q), .b_val(src_val),
    .p_idx(ptr_idx), .p_val(ptr_val), .p_seg(ptr_seg),
    .o_idx(rd_idx), .o_val(rd_val), .o_seg(rd_seg)
  );

  // operand a is always the old value of the destination
  assign opa = mem_dst ? mem_rdata : dst_val;
  assign opb = (mode_q == MODE_RM) ? mem_rdata : src_val;

  rind_addalu #(.DW(DW)) i_alu (
    .a(opa), .b(opb), .byte_op(byte_q), .sum(sum), .carry(c_comb), .zero(z_comb)
  );

  always_comb begin
    c_d = c_q;
    z_d = z_q;
    if (wb_phase) begin
      c_d = c_comb;
      z_d = z_comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (wb_phase) begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end

  assign flag_c    = c_q;
  assign flag_z    = z_q;
  assign mem_addr  = {ptr_seg, ptr_val};
  assign mem_rd    = rd_phase;
  assign mem_we    = wb_phase && mem_dst;
  assign mem_wdata = sum;

  // R3: read and write strobes are exclusive
  assert_rw_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R3: a write lands on the address read in the previous cycle
  assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_rd) && (mem_addr == $past(mem_addr))));

  // R5: pointer moves by the requested step across the advance cycle
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_phase |=> (ptr_val == $past(ptr_val) + $past(inc_amt)));

  // R6: byte result into a register keeps the upper byte
  assert_byte_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && byte_q) |=> (dst_val[DW-1:8] == $past(dst_val[DW-1:8])));

  // R10: no memory traffic while idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_we));
endmodule

// File: tb/test_rind_add_unit.sv
`timescale 1ns/1ps
module test_rind_add_unit;
  logic        clk, rst_n;
  logic        op_start, op_byte, op_autoinc;
  logic [1:0]  op_mode;
  logic [2:0]  op_dst, op_src, ld_idx, rd_idx;
  logic        busy, done, flag_c, flag_z, mem_rd, mem_we, ld_en;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, ld_val, rd_val;
  logic [7:0]  ld_seg, rd_seg;
  logic [15:0] mem [1024];
  logic [23:0] wr_addr_seen;
  int          wr_cnt;
  int          checks = 0;
  int          errors = 0;

  rind_add_unit i_rind_add_unit (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_mode(op_mode),
    .op_dst(op_dst), .op_src(op_src), .op_byte(op_byte), .op_autoinc(op_autoinc),
    .busy(busy), .done(done), .flag_c(flag_c), .flag_z(flag_z),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val), .ld_seg(ld_seg),
    .rd_idx(rd_idx), .rd_val(rd_val), .rd_seg(rd_seg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wr_addr_seen <= mem_addr;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [15:0] v, input logic [7:0] s);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx[2:0]; ld_val = v; ld_seg = s;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [15:0] v, output logic [7:0] s);
    rd_idx = idx[2:0];
    #1;
    v = rd_val;
    s = rd_seg;
  endtask

  task automatic run_op(input logic [1:0] m, input int d, input int s, input logic b,
                        input logic ai, output int lat, output logic [23:0] raddr);
    @(negedge clk);
    op_mode = m; op_dst = d[2:0]; op_src = s[2:0]; op_byte = b; op_autoinc = ai;
    op_start = 1'b1;
    @(posedge clk);
    #1 op_start = 1'b0;
    lat = 0;
    raddr = '0;
    do begin
      @(negedge clk);
      lat++;
      if (mem_rd) raddr = mem_addr;
    end while (!done && lat < 12);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] s;
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 flags", {flag_c, flag_z}, 0);
    chk("R10 strobes", {mem_rd, mem_we}, 0);
    for (int i = 0; i < 8; i++) begin
      peek(i, v, s);
      chk("R10 reg/seg zero", {s, v}, 0);
    end
  endtask

  task automatic t_regreg;
    int lat; logic [23:0] ra; logic [15:0] v; logic [7:0] s; int wc;
    load(1, 16'h1234, 8'h00);
    load(2, 16'h1111, 8'h00);
    wc = wr_cnt;
    run_op(2'd0, 1, 2, 1'b0, 1'b0, lat, ra);
    peek(1, v, s); chk("R1 sum", v, 16'h2345);
    peek(2, v, s); chk("R1 src unchanged", v, 16'h1111);
    chk("R1 no mem", {ra, 8'(wr_cnt - wc)}, 0);
    chk("R8 reg latency", lat, 2);
    chk("R7 flags nonzero", {flag_c, flag_z}, 2'b00);
    load(3, 16'hFFFF, 8'h00);
    load(4, 16'h0001, 8'h00);
    run_op(2'd3, 3, 4, 1'b0, 1'b0, lat, ra);
    peek(3, v, s); chk("R1 wrap mode3", v, 16'h0000);
    chk("R7 word carry+zero", {flag_c, flag_z}, 2'b11);
  endtask

  task automatic t_regmem;
    int lat; logic [23:0] ra; logic [15:0] v; logic [7:0] s;
    load(5, 16'h0100, 8'h3A);
    load(1, 16'h0005, 8'h00);
    mem[10'h100] = 16'h0010;
    run_op(2'd1, 1, 5, 1'b0, 1'b1, lat, ra);
    peek(1, v, s); chk("R2 reg+mem", v, 16'h0015);
    chk("R4 address", ra, 24'h3A0100);
    peek(5, v, s); chk("R5 word step", {s, v}, 24'h3A0102);
    chk("R8 mem latency", lat, 4);
  endtask

  task automatic t_memreg;
    int lat; logic [23:0] ra; logic [15:0] v; logic [7:0] s; int wc;
    load(6, 16'h0200, 8'h12);
    load(2, 16'h0003, 8'h00);
    mem[10'h200] = 16'h7FFF;
    wc = wr_cnt;
    run_op(2'd2, 6, 2, 1'b0, 1'b0, lat, ra);
    chk("R3 mem result", mem[10'h200], 16'h8002);
    chk("R3 one write", wr_cnt - wc, 1);
    chk("R3 write addr = read addr", wr_addr_seen, ra);
    chk("R4 seg above ptr", ra, 24'h120200);
    peek(6, v, s); chk("R5 no autoinc", v, 16'h0200);
    peek(2, v, s); chk("R3 src reg unchanged", v, 16'h0003);
    chk("R8 mem latency", lat, 4);
  endtask

  task automatic t_byte;
    int lat; logic [23:0] ra; logic [15:0] v; logic [7:0] s;
    load(1, 16'hAB80, 8'h00);
    load(2, 16'h1290, 8'h00);
    run_op(2'd0, 1, 2, 1'b1, 1'b0, lat, ra);
    peek(1, v, s); chk("R6 byte reg keeps upper", v, 16'hAB10);
    chk("R7 byte carry", {flag_c, flag_z}, 2'b10);
    load(6, 16'h0300, 8'h00);
    load(3, 16'h0010, 8'h00);
    mem[10'h300] = 16'h55F0;
    run_op(2'd2, 6, 3, 1'b1, 1'b1, lat, ra);
    chk("R6 byte mem keeps upper", mem[10'h300], 16'h5500);
    chk("R7 byte carry+zero", {flag_c, flag_z}, 2'b11);
    peek(6, v, s); chk("R5 byte step", v, 16'h0301);
  endtask

  task automatic t_busy;
    logic [15:0] v; logic [7:0] s;
    load(1, 16'h0001, 8'h00);
    load(2, 16'h0002, 8'h00);
    @(negedge clk);
    op_mode = 2'd0; op_dst = 3'd1; op_src = 3'd2; op_byte = 1'b0; op_autoinc = 1'b0;
    op_start = 1'b1;
    @(posedge clk);
    #1;
    op_dst = 3'd2; op_src = 3'd1;
    ld_en = 1'b1; ld_idx = 3'd2; ld_val = 16'hDEAD; ld_seg = 8'h77;
    @(negedge clk);
    chk("R8 busy after start", busy, 1);
    @(negedge clk);
    chk("R8 done", done, 1);
    op_start = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    chk("R8 done single", {done, busy}, 0);
    repeat (3) @(negedge clk);
    peek(1, v, s); chk("R9 one add only", v, 16'h0003);
    peek(2, v, s); chk("R9 load ignored", {s, v}, 24'h000002);
    chk("R9 no restart", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; op_start = 1'b0; op_mode = '0; op_dst = '0; op_src = '0;
    op_byte = 1'b0; op_autoinc = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_val = '0;
    ld_seg = '0; rd_idx = '0; wr_cnt = 0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regreg;
    t_regmem;
    t_memreg;
    t_byte;
    t_busy;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule